// File: doc/BRIEF.md
# Cascadable Serial-to-Latch Channel Controller

This block is the digital control side of a sixteen-channel constant-current sink array. A host sends one on/off bit per channel over a simple serial link (a data line and a shift clock). Each rising shift-clock edge pushes one bit into a shift register. The last stage of that register is driven back out, so several controllers can be chained by wiring one device's serial output to the next device's serial input.

A level-sensitive load input copies the shift register into a holding register. The copy follows the shift register while load is high and freezes when load falls. A blank input and an optional over-temperature input each force every channel enable low, and the held data is kept. The registers are cleared by a power-on/undervoltage reset.

All control pins are asynchronous to the block. Each one is brought into the system clock domain through a two-flop synchronizer. The serial clock is edge-detected after its synchronizer.

Top module: `chan_latch_ctrl`

## Requirements
- R1: While `rst_n` is low, the shift register, the holding register, `ch_en` and `ser_dout` are cleared to zero at the next system clock edge and stay zero.
- R2: Each rising edge of `ser_clk` moves the shift register up by one stage and puts `ser_din` into stage 0. A falling edge of `ser_clk` leaves the register unchanged. `ser_dout` carries stage 15, so after 16 rising edges it shows the first bit that was sent.
- R3: `ch_en[0]` is channel 1. After a 16-bit frame with `load` high, the first bit sent controls `ch_en[15]` and the last bit sent controls `ch_en[0]`.
- R4: While `load` is high and both `blank` and `therm_fault` are low, `ch_en` follows the shift register contents bit by bit, including in the middle of a frame.
- R5: While `load` is low, further shifting does not change `ch_en`. The contents present when `load` fell are kept, and raising `load` again transfers the newer data.
- R6: While `blank` is high, every bit of `ch_en` is 0. After `blank` returns low, `ch_en` again shows the unchanged held data. `blank` powers up as asserted.
- R7: While `therm_fault` is high, every bit of `ch_en` is 0, and the held data is kept in the same way as for `blank`.
- R8: `ser_clk` edges and `load` pulses that arrive while `rst_n` is low have no effect. After release, `ser_dout` and `ch_en` are still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is updated on its rising edge |
| rst_n | input | 1 | Synchronous active-low power-on/undervoltage reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_din | input | 1 | Serial data bit, sampled on a rising `ser_clk` edge |
| ser_dout | output | 1 | Last shift-register stage, for chaining to the next device |
| load | input | 1 | High: holding register tracks the shift register; falling edge freezes it |
| blank | input | 1 | High forces all channel enables off |
| therm_fault | input | 1 | High forces all channel enables off (over-temperature) |
| ch_en | output | 16 | Channel enables; bit 0 is channel 1 |

## Verification
The assertions check three things on every cycle. First, `ch_en` is zero after a few cycles of `blank` or `therm_fault` held high. Second, `ch_en` stays stable once `load`, `blank` and `therm_fault` have all been low long enough to pass the synchronizers. Third, both outputs are zero on the first cycle after reset.

Some behaviours depend on a particular serial bit sequence, so only the bench's directed scenarios can show them: bit ordering across the chain output, the channel mapping, the partial-frame view while `load` is high, newer data being picked up by a second load pulse, and serial activity being ignored during reset.

// File: rtl/clc_pkg.sv
// Package: shared constants and the synchronized control bundle used by the
// channel controller. Assumes every control pin is asynchronous to clk.
package clc_pkg;
    // Default channel count of one controller.
    parameter int CLC_CHANNELS = 16;
    // Number of flops in each input synchronizer.
    parameter int CLC_SYNC_STAGES = 2;

    // Control levels after they are brought into the clk domain.
    typedef struct packed {
        logic load;
        logic blank;
        logic fault;
    } clc_ctl_t;
endpackage

// File: rtl/clc_sync.sv
// Module: multi-stage level synchronizer with a chosen reset value.
// Assumes the inputs are slow levels (wider than a few clk periods) and that
// each bit may be resynchronized on its own.
module clc_sync #(
    parameter int         WIDTH   = 1,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Stage 0 captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
    end

    // Later stages give metastability time to resolve.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/clc_shift.sv
// Module: serial shift register driven by a sampled shift clock.
// The shift clock and data pass through the same synchronizer, so they stay
// aligned. A rising edge of the synchronized clock shifts the data in at
// stage 0. Assumes the shift clock high and low times each last at least
// three clk periods. The clock synchronizer resets high, so a clock that is
// already high at reset release does not count as an edge.
module clc_shift #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_raw,
    input  logic         sdin_raw,
    output logic [N-1:0] shreg,
    output logic         sdo
);
    logic [1:0] sync_q;
    logic       sclk_prev;
    logic       sclk_rise;

    clc_sync #(.WIDTH(2), .STAGES(STAGES), .RST_VAL(2'b10)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk_raw, sdin_raw}),
        .q    (sync_q)
    );

    // Previous synchronized clock level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= sync_q[1];
    end

    assign sclk_rise = sync_q[1] & ~sclk_prev;

    // Shift one stage up on each detected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg <= '0;
        else if (sclk_rise) shreg <= {shreg[N-2:0], sync_q[0]};
    end

    assign sdo = shreg[N-1];
endmodule

// File: rtl/clc_hold.sv
// Module: holding register and output gate. While load is high, the holding
// register copies the shift register each cycle; while load is low, it keeps
// its value. The channel enables are registered, and they are forced low
// whenever blank or the fault level is high. Assumes synchronized controls.
module clc_hold #(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         shreg,
    input  clc_pkg::clc_ctl_t    ctl,
    output logic [N-1:0]         ch_en
);
    logic [N-1:0] held_q;
    logic         gate_off;

    // Track the shift register while load is high; freeze it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        held_q <= '0;
        else if (ctl.load) held_q <= shreg;
    end

    assign gate_off = ctl.blank | ctl.fault;

    // Registered channel enables, forced off by blank or fault.
    always_ff @(posedge clk) begin
        if (!rst_n)        ch_en <= '0;
        else if (gate_off) ch_en <= '0;
        else               ch_en <= held_q;
    end
endmodule

// File: rtl/chan_latch_ctrl.sv
// Module: top of the cascadable serial-to-latch channel controller.
// Brings load, blank and the optional fault input into the clk domain, then
// connects the shift and hold stages. When HAS_FAULT is 0, therm_fault is
// ignored. Assumes rst_n comes from power-on/undervoltage detection.
module chan_latch_ctrl #(
    parameter int N         = clc_pkg::CLC_CHANNELS,
    parameter int STAGES    = clc_pkg::CLC_SYNC_STAGES,
    parameter bit HAS_FAULT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_din,
    output logic         ser_dout,
    input  logic         load,
    input  logic         blank,
    input  logic         therm_fault,
    output logic [N-1:0] ch_en
);
    logic [N-1:0]       shreg;
    logic [1:0]         lb_sync;
    logic               fault_s;
    clc_pkg::clc_ctl_t  ctl;

    // load resets to idle (low); blank resets to asserted (high).
    clc_sync #(.WIDTH(2), .STAGES(STAGES), .RST_VAL(2'b01)) u_lb_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({load, blank}),
        .q    (lb_sync)
    );

    if (HAS_FAULT) begin : g_fault
        clc_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_fault_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (therm_fault),
            .q    (fault_s)
        );
    end else begin : g_nofault
        assign fault_s = 1'b0;
    end

    assign ctl = '{load: lb_sync[1], blank: lb_sync[0], fault: fault_s};

    clc_shift #(.N(N), .STAGES(STAGES)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_raw(ser_clk),
        .sdin_raw(ser_din),
        .shreg   (shreg),
        .sdo     (ser_dout)
    );

    clc_hold #(.N(N)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .shreg(shreg),
        .ctl  (ctl),
        .ch_en(ch_en)
    );
endmodule

// File: rtl/clc_checker.sv
// Module: property checker for chan_latch_ctrl, attached by bind. It uses
// counters to measure how long an input level has been held, so that each
// window covers the synchronizer plus the output register.
module clc_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load,
    input logic         blank,
    input logic         therm_fault,
    input logic         ser_dout,
    input logic [N-1:0] ch_en
);
    logic [2:0] blank_cnt = '0;
    logic [2:0] fault_cnt = '0;
    logic [2:0] quiet_cnt = '0;
    logic       was_in_rst = 1'b0;

    // Count consecutive cycles of each watched level, saturating at 7.
    always_ff @(posedge clk) begin
        was_in_rst <= !rst_n;
        if (!rst_n) begin
            blank_cnt <= '0;
            fault_cnt <= '0;
            quiet_cnt <= '0;
        end else begin
            blank_cnt <= blank ? ((blank_cnt == 3'd7) ? blank_cnt : blank_cnt + 3'd1) : 3'd0;
            fault_cnt <= therm_fault ? ((fault_cnt == 3'd7) ? fault_cnt : fault_cnt + 3'd1) : 3'd0;
            quiet_cnt <= (!load && !blank && !therm_fault)
                         ? ((quiet_cnt == 3'd7) ? quiet_cnt : quiet_cnt + 3'd1) : 3'd0;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_in_rst |-> (ch_en == '0 && ser_dout == 1'b0));

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt >= 3'd6) |-> $stable(ch_en));

    p_blank_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_cnt >= 3'd4) |-> (ch_en == '0));

    p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cnt >= 3'd4) |-> (ch_en == '0));
endmodule

bind chan_latch_ctrl clc_checker #(.N(N)) u_clc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .blank      (blank),
    .therm_fault(therm_fault),
    .ser_dout   (ser_dout),
    .ch_en      (ch_en)
);

// File: tb/chan_latch_ctrl_bench.sv
// Directed bench for chan_latch_ctrl: one task per scenario.
module chan_latch_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        load = 1'b0;
    logic        blank = 1'b1;
    logic        therm_fault = 1'b0;
    logic        ser_dout;
    logic [15:0] ch_en;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    chan_latch_ctrl u_chan_latch_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_dout(ser_dout), .load(load), .blank(blank),
        .therm_fault(therm_fault), .ch_en(ch_en)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
        ser_clk = 1'b0;
        wait_n(4);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic t_reset;
        wait_n(3);
        chk("R1 ch_en in reset", ch_en, 16'h0);
        chk("R1 dout in reset", {15'b0, ser_dout}, 16'h0);
        rst_n = 1'b1;
        wait_n(6);
        chk("R6 blank default keeps outputs off", ch_en, 16'h0);
    endtask

    task automatic t_transparent;
        blank = 1'b0;
        load  = 1'b1;
        for (int i = 15; i >= 8; i--) send_bit(16'h3C96 >> i);
        wait_n(6);
        chk("R4 partial frame visible", ch_en, 16'h003C);
        for (int i = 7; i >= 0; i--) send_bit(16'h3C96 >> i);
        wait_n(6);
        chk("R4 full frame visible", ch_en, 16'h3C96);
    endtask

    task automatic t_mapping;
        send_bit(1'b1);
        for (int i = 0; i < 15; i++) send_bit(1'b0);
        wait_n(6);
        chk("R3 first bit -> channel 16", ch_en, 16'h8000);
        for (int i = 0; i < 15; i++) send_bit(1'b0);
        send_bit(1'b1);
        wait_n(6);
        chk("R3 last bit -> channel 1", ch_en, 16'h0001);
    endtask

    task automatic t_hold;
        send_word(16'h5A0F);
        wait_n(6);
        load = 1'b0;
        wait_n(6);
        send_word(16'hC3E1);
        wait_n(6);
        chk("R5 held while load low", ch_en, 16'h5A0F);
        load = 1'b1;
        wait_n(6);
        load = 1'b0;
        wait_n(6);
        chk("R5 new data after load pulse", ch_en, 16'hC3E1);
        send_word(16'h0000);
        wait_n(6);
        chk("R5 frozen after falling load", ch_en, 16'hC3E1);
    endtask

    task automatic t_blank;
        blank = 1'b1;
        wait_n(6);
        chk("R6 blank forces off", ch_en, 16'h0);
        blank = 1'b0;
        wait_n(6);
        chk("R6 data kept after blank", ch_en, 16'hC3E1);
    endtask

    task automatic t_fault;
        therm_fault = 1'b1;
        wait_n(6);
        chk("R7 fault forces off", ch_en, 16'h0);
        therm_fault = 1'b0;
        wait_n(6);
        chk("R7 data kept after fault", ch_en, 16'hC3E1);
    endtask

    task automatic t_chain_out;
        send_word(16'hA5C3);
        chk("R2 dout shows first bit", {15'b0, ser_dout}, 16'h1);
        send_bit(1'b0);
        chk("R2 dout after extra bit", {15'b0, ser_dout}, 16'h0);
        ser_din = 1'b1;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(6);
        chk("R2 dout after rising edge", {15'b0, ser_dout}, 16'h1);
        ser_clk = 1'b0;
        wait_n(6);
        chk("R2 falling edge no shift", {15'b0, ser_dout}, 16'h1);
        send_bit(1'b0);
        chk("R2 dout after next rise", {15'b0, ser_dout}, 16'h0);
    endtask

    task automatic t_reset_ignore;
        rst_n = 1'b0;
        wait_n(3);
        chk("R1 ch_en cleared by reset", ch_en, 16'h0);
        load  = 1'b1;
        blank = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        chk("R8 dout low during reset", {15'b0, ser_dout}, 16'h0);
        rst_n = 1'b1;
        wait_n(8);
        chk("R8 outputs clear after release", ch_en, 16'h0);
        chk("R8 dout clear after release", {15'b0, ser_dout}, 16'h0);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_mapping();
        t_hold();
        t_blank();
        t_fault();
        t_chain_out();
        t_reset_ignore();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule